// File: doc/BRIEF.md
# I2C Raw Interrupt Status

This block holds the unmasked interrupt flags of an I2C controller. The master and slave protocol engines report events to it as single-cycle pulses. Examples are an acknowledged general call address, a START/RESTART, a STOP, bus activity, a NACK seen as slave transmitter, a transmit abort and a slave read request. The block also watches the FIFO fill levels, the TX and RX thresholds, the enable and the state-machine busy indication, and derives from them the level flags and the overflow and underflow flags.

Software reads the flags as a 16-bit word. A read of a per-flag clear register, or of the combined clear register, arrives as a one-cycle strobe. Each flag has its own rules for set and clear, and its own behaviour when the controller is disabled. While a slave read request is pending, the block asks the bus engine to hold SCL low. The status word is registered, so every flag change shows one clock edge after its cause.

Top module: `i2c_raw_irq_status`

## Requirements
- R1: After reset the status word is 0. Bits 15..12 always read 0. Flag positions, bit 11 down to 0: general call, start, stop, activity, slave-transmit done, transmit abort, read request, TX empty, TX overflow, RX full, RX overflow, RX underflow.
- R2: A pulse on `ev_set[i]` for i in 5..11 sets status bit i at the next edge. The bit then stays set. When a set pulse and a clear strobe for the same bit arrive in the same cycle, the bit ends up set. Positions 0..4 of `ev_set` are ignored.
- R3: A strobe on `clr_rd[i]` clears sticky bit i (any of 11..5, 3, 1, 0) at the next edge. `clr_rd[2]` and `clr_rd[4]` have no effect. `scl_hold` is high exactly while status bit 5 is set.
- R4: A strobe on `clr_all` clears every sticky bit (11..5, 3, 1, 0) at the next edge and leaves bits 4 and 2 alone.
- R5: While `enable` is low, the general-call bit (11) and the activity bit (8) are forced to 0, even against a set pulse. The start bit (10) and the stop bit (9) are not affected by `enable`.
- R6: Bit 4 shows `tx_level <= tx_thresh` while enabled. While disabled it shows `sm_busy`.
- R7: Bit 2 shows `rx_level >= rx_thresh` while enabled. It is 0 whenever `enable` is low, whatever the value of `sm_busy`.
- R8: A `tx_wr` strobe while `tx_level` equals FIFO_DEPTH sets bit 3. An `rx_wr` strobe while `rx_level` equals FIFO_DEPTH sets bit 1. An `rx_rd` strobe while `rx_level` is 0 sets bit 0. The same strobes at other levels set nothing.
- R9: While `enable` is low and `sm_busy` is high, bits 3, 1 and 0 keep their value. While both `enable` and `sm_busy` are low, they are forced to 0.
- R10: A software write (`sw_wr` with any `sw_wdata`) changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Controller enable |
| sm_busy | input | 1 | A master or slave state machine is not idle |
| ev_set | input | 12 | Event pulses indexed by status bit; only 11..5 are used |
| tx_level | input | LVL_W | TX FIFO fill level |
| tx_thresh | input | LVL_W | TX threshold |
| rx_level | input | LVL_W | RX FIFO fill level |
| rx_thresh | input | LVL_W | RX threshold |
| tx_wr | input | 1 | Software push into the TX FIFO |
| rx_wr | input | 1 | Received byte pushed into the RX FIFO |
| rx_rd | input | 1 | Software pop from the RX FIFO |
| clr_rd | input | 12 | Per-flag clear-register read strobes, indexed by status bit |
| clr_all | input | 1 | Combined clear-register read strobe |
| sw_wr | input | 1 | Software write to the status word |
| sw_wdata | input | 16 | Data of that write |
| status | output | 16 | Raw interrupt status word |
| scl_hold | output | 1 | Request to stretch SCL while a read request is pending |

## Verification
The bench builds the block with FIFO_DEPTH = 4, which makes the level ports 3 bits wide. With that depth, the full and empty boundaries of both FIFOs are reached directly. This makes it possible to drive overflow and underflow strobes both at the boundary and one level below it. It also lets the bench sweep the threshold comparisons across equal, above and below.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int STAT_W    = 16;
  localparam int NUM_FLAGS = 12;

  localparam int B_RX_UNDER = 0;
  localparam int B_RX_OVER  = 1;
  localparam int B_RX_FULL  = 2;
  localparam int B_TX_OVER  = 3;
  localparam int B_TX_EMPTY = 4;
  localparam int B_RD_REQ   = 5;
  localparam int B_TX_ABORT = 6;
  localparam int B_SLV_DONE = 7;
  localparam int B_ACTIVITY = 8;
  localparam int B_STOP     = 9;
  localparam int B_START    = 10;
  localparam int B_GEN_CALL = 11;

  // flags held in a set/clear cell (all but the two level flags)
  localparam logic [NUM_FLAGS-1:0] STICKY_MASK   = 12'hFEB;
  // flags set directly by engine event pulses
  localparam logic [NUM_FLAGS-1:0] EVENT_MASK    = 12'hFE0;
  // flags forced clear whenever enable is low
  localparam logic [NUM_FLAGS-1:0] DIS_CLR_MASK  = 12'h900;
  // flags forced clear once disabled and the state machines are idle
  localparam logic [NUM_FLAGS-1:0] IDLE_CLR_MASK = 12'h00B;
endpackage

// File: rtl/i2c_irq_sticky.sv
module i2c_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd_clr,
  input  logic hw_clr,
  output logic q
);
  logic q_d;

  // priority: hardware clear, then set, then read clear
  always_comb begin
    q_d = q;
    if (hw_clr)      q_d = 1'b0;
    else if (set)    q_d = 1'b1;
    else if (rd_clr) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set && !hw_clr |=> q); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !set && !hw_clr |=> !q); // R3
  AST_HW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> !q); // R5
  AST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !set && !rd_clr && !hw_clr |=> q == $past(q)); // R2
endmodule

// File: rtl/i2c_irq_levels.sv
module i2c_irq_levels #(
  parameter int FIFO_DEPTH = 32,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sm_busy,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic             tx_wr,
  input  logic             rx_wr,
  input  logic             rx_rd,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             tx_over_ev,
  output logic             rx_over_ev,
  output logic             rx_under_ev
);
  localparam logic [LVL_W-1:0] FULL_LVL  = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] EMPTY_LVL = '0;

  logic tx_empty_d, rx_full_d;

  always_comb begin
    tx_empty_d = enable ? (tx_level <= tx_thresh) : sm_busy;
    rx_full_d  = enable && (rx_level >= rx_thresh);
  end

  assign tx_over_ev  = tx_wr && (tx_level == FULL_LVL);
  assign rx_over_ev  = rx_wr && (rx_level == FULL_LVL);
  assign rx_under_ev = rx_rd && (rx_level == EMPTY_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b0;
      rx_full  <= 1'b0;
    end else begin
      tx_empty <= tx_empty_d;
      rx_full  <= rx_full_d;
    end
  end

  AST_TXEMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !sm_busy |=> !tx_empty); // R6
  AST_RXFULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rx_full); // R7
endmodule

// File: rtl/i2c_raw_irq_status.sv
module i2c_raw_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 sm_busy,
  input  logic [NUM_FLAGS-1:0] ev_set,
  input  logic [LVL_W-1:0]     tx_level,
  input  logic [LVL_W-1:0]     tx_thresh,
  input  logic [LVL_W-1:0]     rx_level,
  input  logic [LVL_W-1:0]     rx_thresh,
  input  logic                 tx_wr,
  input  logic                 rx_wr,
  input  logic                 rx_rd,
  input  logic [NUM_FLAGS-1:0] clr_rd,
  input  logic                 clr_all,
  input  logic                 sw_wr,
  input  logic [STAT_W-1:0]    sw_wdata,
  output logic [STAT_W-1:0]    status,
  output logic                 scl_hold
);
  logic [1:0]           rst_sync;
  logic                 rst_sync_n;
  logic [NUM_FLAGS-1:0] flags, set_vec, rdclr_vec, hwclr_vec;
  logic                 tx_empty, rx_full, tx_over_ev, rx_over_ev, rx_under_ev;
  logic                 sw_write_unused;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  // the status word takes no writes
  assign sw_write_unused = sw_wr ^ (^sw_wdata);

  i2c_irq_levels #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_levels (
    .clk(clk), .rst_n(rst_sync_n), .enable(enable), .sm_busy(sm_busy),
    .tx_level(tx_level), .tx_thresh(tx_thresh),
    .rx_level(rx_level), .rx_thresh(rx_thresh),
    .tx_wr(tx_wr), .rx_wr(rx_wr), .rx_rd(rx_rd),
    .tx_empty(tx_empty), .rx_full(rx_full),
    .tx_over_ev(tx_over_ev), .rx_over_ev(rx_over_ev), .rx_under_ev(rx_under_ev)
  );

  always_comb begin
    set_vec             = ev_set & EVENT_MASK;
    set_vec[B_TX_OVER]  = tx_over_ev;
    set_vec[B_RX_OVER]  = rx_over_ev;
    set_vec[B_RX_UNDER] = rx_under_ev;
    rdclr_vec = (clr_rd | {NUM_FLAGS{clr_all}}) & STICKY_MASK;
    hwclr_vec = (DIS_CLR_MASK  & {NUM_FLAGS{~enable}}) |
                (IDLE_CLR_MASK & {NUM_FLAGS{~enable & ~sm_busy}});
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    if (STICKY_MASK[i]) begin : g_sticky
      i2c_irq_sticky u_cell (
        .clk(clk), .rst_n(rst_sync_n), .set(set_vec[i]),
        .rd_clr(rdclr_vec[i]), .hw_clr(hwclr_vec[i]), .q(flags[i])
      );
    end else if (i == B_TX_EMPTY) begin : g_txe
      assign flags[i] = tx_empty;
    end else begin : g_rxf
      assign flags[i] = rx_full;
    end
  end

  assign status   = {{(STAT_W-NUM_FLAGS){1'b0}}, flags};
  assign scl_hold = flags[B_RD_REQ];

  AST_GC_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enable |=> !status[B_GEN_CALL] && !status[B_ACTIVITY]); // R5
  AST_OVER_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enable && sm_busy && !clr_all && !clr_rd[B_TX_OVER] && !tx_over_ev
      |=> status[B_TX_OVER] == $past(status[B_TX_OVER])); // R9
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_all && !ev_set[B_START] |=> !status[B_START]); // R4
endmodule

// File: tb/i2c_raw_irq_status_test.sv
module i2c_raw_irq_status_test;
  localparam int DEPTH = 4;
  localparam int LW    = 3;

  logic        clk = 1'b0;
  logic        rst_n, enable, sm_busy, tx_wr, rx_wr, rx_rd, clr_all, sw_wr;
  logic [11:0] ev_set, clr_rd;
  logic [LW-1:0] tx_level, tx_thresh, rx_level, rx_thresh;
  logic [15:0] sw_wdata, status;
  logic        scl_hold;

  int checks = 0;
  int errors = 0;
  logic [11:0] model_q = '0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  i2c_raw_irq_status #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sm_busy(sm_busy),
    .ev_set(ev_set), .tx_level(tx_level), .tx_thresh(tx_thresh),
    .rx_level(rx_level), .rx_thresh(rx_thresh),
    .tx_wr(tx_wr), .rx_wr(rx_wr), .rx_rd(rx_rd),
    .clr_rd(clr_rd), .clr_all(clr_all), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .status(status), .scl_hold(scl_hold)
  );

  // expected next flags from the requirement rules
  function automatic logic [11:0] predict(logic [11:0] cur);
    logic [11:0] nx;
    for (int i = 0; i < 12; i++) begin
      logic s, rc, hc;
      s  = (i >= 5) ? ev_set[i] :
           (i == 3) ? (tx_wr && tx_level == LW'(DEPTH)) :
           (i == 1) ? (rx_wr && rx_level == LW'(DEPTH)) :
           (i == 0) ? (rx_rd && rx_level == 0) : 1'b0;
      rc = clr_rd[i] | clr_all;
      hc = ((i == 11 || i == 8) && !enable) ||
           ((i == 3 || i == 1 || i == 0) && !enable && !sm_busy);
      nx[i] = hc ? 1'b0 : s ? 1'b1 : rc ? 1'b0 : cur[i];
    end
    nx[4] = enable ? (tx_level <= tx_thresh) : sm_busy;
    nx[2] = enable && (rx_level >= rx_thresh);
    return nx;
  endfunction

  task automatic nx_cycle();
    @(negedge clk);
    ev_set = '0; clr_rd = '0; clr_all = 0; tx_wr = 0; rx_wr = 0; rx_rd = 0;
    sw_wr = 0; sw_wdata = '0;
  endtask

  // driver: push expected result of the inputs now applied
  task automatic push(string tag);
    model_q = predict(model_q);
    exp_q.push_back(model_q);
    tag_q.push_back(tag);
  endtask

  task automatic step(string tag);
    push(tag);
    nx_cycle();
  endtask

  // monitor: compare one cycle after each pushed item
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (status !== {4'b0, e} || scl_hold !== e[5]) begin
        errors++;
        $display("FAIL %s: status=%h hold=%b expected status=%h hold=%b",
                 t, status, scl_hold, {4'b0, e}, e[5]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 1; sm_busy = 0;
    tx_level = 0; tx_thresh = 0; rx_level = 0; rx_thresh = 3;
    ev_set = '0; clr_rd = '0; clr_all = 0; tx_wr = 0; rx_wr = 0; rx_rd = 0;
    sw_wr = 0; sw_wdata = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (status !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset: status=%h expected 0000", status);
    end
    rst_n = 1;
    repeat (3) @(negedge clk);
    nx_cycle();
    step("R6 idle enabled TX empty");
    // R2 each event bit, one at a time
    for (int b = 5; b < 12; b++) begin
      ev_set[b] = 1'b1; step("R2 event sets bit");
    end
    ev_set[3:0] = 4'hF; ev_set[4] = 1'b1; step("R2 low event positions ignored");
    step("R2 bits held");
    // R3 individual clears
    clr_rd[5] = 1; step("R3 clear read request releases SCL");
    clr_rd[2] = 1; clr_rd[4] = 1; step("R3 level positions unaffected by clear");
    clr_rd[9] = 1; ev_set[9] = 1; step("R2 set beats clear same cycle");
    clr_rd[10] = 1; step("R3 clear start");
    // R6/R7 level tracking
    tx_level = 3; tx_thresh = 1; rx_level = 3; rx_thresh = 3; step("R6 R7 above/equal");
    rx_level = 2; tx_level = 1; step("R6 R7 equal/below");
    rx_level = 4; tx_level = 2; step("R6 R7 again");
    // R8 overflow/underflow
    tx_level = 3; tx_wr = 1; step("R8 tx write one below full");
    tx_level = 4; tx_wr = 1; step("R8 tx write when full");
    rx_wr = 1; rx_level = 3; step("R8 rx push one below full");
    rx_wr = 1; rx_level = 4; step("R8 rx push when full");
    rx_rd = 1; rx_level = 1; step("R8 rx pop not empty");
    rx_rd = 1; rx_level = 0; step("R8 rx pop when empty");
    // R10 software write
    sw_wr = 1; sw_wdata = 16'hFFFF; step("R10 write ones ignored");
    sw_wr = 1; sw_wdata = 16'h0000; step("R10 write zeros ignored");
    // R4 combined clear
    ev_set[10] = 1; ev_set[5] = 1; rx_level = 4; step("R4 prepare");
    clr_all = 1; step("R4 combined clear");
    // refill sticky flags
    ev_set = 12'hFE0; tx_level = 4; tx_wr = 1; rx_wr = 1; step("R4 refill");
    rx_rd = 1; rx_level = 0; step("R4 refill underflow");
    // R5/R9/R6/R7 disable with busy
    enable = 0; sm_busy = 1; rx_level = 4; step("R5 R9 disable busy");
    ev_set[11] = 1; ev_set[8] = 1; step("R5 set pulse while disabled");
    step("R9 held while busy");
    sm_busy = 0; step("R9 R6 idle clears");
    ev_set[10] = 1; ev_set[9] = 1; step("R5 start stop while disabled");
    step("R5 start stop held");
    enable = 1; step("R6 re-enable");
    clr_all = 1; ev_set[6] = 1; step("R2 set beats combined clear");
    nx_cycle();
    nx_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule